// File: doc/BRIEF.md
# Bidirectional Longitudinal Time Code Receiver

This block turns the digital output of a line comparator into time code frames. The incoming stream uses biphase-mark coding. Every bit cell begins with a transition, and a one adds a second transition in mid-cell. The receiver measures the clock count between transitions against a running estimate of the bit period, which lets it follow tape that is shuttled slowly or wound fast. It slices the intervals into bits and looks for the 16-bit sync word. It accepts the word as sent in normal play, and also its mirror image, which appears when the medium runs backward.

After a sync word the next 64 bits are a frame's data. The block places them into an eight-byte read buffer, always in forward bit order, and then pulses a receive interrupt. A lock flag and a direction flag tell software whether frames are arriving and which way the tape is moving. Software reads the buffer one byte at a time through a three-bit address.

Top module: `ltc_rx`

## Requirements
- R1: After reset, `lock`, `dir_bwd` and `rx_irq` are 0 and every buffer byte reads 0.
- R2: When the bits 0011_1111_1111_1101 arrive left bit first, `lock` goes to 1 and `dir_bwd` to 0.
- R3: When the bits 1011_1111_1111_1100 arrive left bit first, `lock` goes to 1 and `dir_bwd` to 1.
- R4: In forward play, the n-th bit after the sync word (n = 0..63) is stored in byte n/8, bit n%8, as read on `rd_data` with `rd_addr` = n/8.
- R5: In backward play, the 64 bits after the sync word arrive as frame bit 63 first down to bit 0. They are stored in the same positions as in R4.
- R6: `rx_irq` is a one-cycle pulse, raised once after the 64th data bit that follows a valid sync word. Data that no sync word precedes is never reported.
- R7: The buffer changes only in the cycle of `rx_irq`. A frame that is aborted or never synced leaves the previous contents readable.
- R8: While locked, if the 16 bits after a frame's data are not the sync word of the current direction, `lock` drops to 0.
- R9: `lock` drops to 0 on an invalid bit (a half cell followed by a full cell). It also drops when no transition arrives for 2·NOM_PERIOD·SLOW_DIV clocks. The first transition after reset or after such a silence only starts timing and yields no bit.
- R10: An interval shorter than 3/4 of the period estimate is a half cell. Two successive half cells decode as 1, and a single full cell decodes as 0.
- R11: Each zero cell moves the period estimate by a moving average with weight 2^-AVG_SHIFT. The estimate is clamped to [NOM_PERIOD/FAST_MUL, NOM_PERIOD·SLOW_DIV], so decoding follows gradual speed changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ltc_line | input | 1 | Comparator output carrying the biphase-mark stream |
| rd_addr | input | 3 | Byte select for the read buffer |
| rd_data | output | 8 | Selected buffer byte |
| lock | output | 1 | 1 while frames are being received |
| dir_bwd | output | 1 | 1 for backward play, 0 for forward; valid while `lock` is 1 |
| rx_irq | output | 1 | One-cycle pulse when a frame is placed in the buffer |

## Verification
Several internal faults show up at the ports:
- A slicer whose pairing state is out of step decodes wrong bits. This shows within one frame as a missing `lock`, a missing `rx_irq`, or wrong buffer bytes.
- A framer counter off by one shifts every stored bit. This is visible in the byte values read right after the interrupt.
- A period estimate that fails to adapt makes the decoder misread cells shortly after a speed change. The interrupt for the faster frame then never comes.
- A stuck direction or lock flag can be read a few clocks after the last sync bit is decoded.

// File: rtl/ltc_rx_pkg.sv
package ltc_rx_pkg;
   localparam int unsigned DATA_BITS = 64;
   localparam int unsigned SYNC_BITS = 16;
   localparam int unsigned BYTE_CNT  = DATA_BITS / 8;
   // Sync word as received, oldest bit in the MSB.
   localparam logic [SYNC_BITS-1:0] SYNC_FWD = 16'h3FFD;
   localparam logic [SYNC_BITS-1:0] SYNC_BWD = 16'hBFFC;

   typedef enum logic [1:0] {
      FR_HUNT = 2'd0,
      FR_DATA = 2'd1,
      FR_SYNC = 2'd2
   } frm_state_t;
endpackage

// File: rtl/ltc_rx_edge_timer.sv
module ltc_rx_edge_timer #(
   parameter int unsigned TIMEOUT = 48000,
   parameter int unsigned CNT_W   = $clog2(TIMEOUT + 2)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             line_in,
   output logic             edge_stb,
   output logic [CNT_W-1:0] iv,
   output logic             tmo_stb
);
   logic             s_meta, s_sync, s_prev;
   logic             stale;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         s_meta   <= 1'b0;
         s_sync   <= 1'b0;
         s_prev   <= 1'b0;
         cnt      <= '0;
         stale    <= 1'b1;
         edge_stb <= 1'b0;
         iv       <= '0;
         tmo_stb  <= 1'b0;
      end else begin
         s_meta   <= line_in;
         s_sync   <= s_meta;
         s_prev   <= s_sync;
         edge_stb <= 1'b0;
         tmo_stb  <= 1'b0;
         if (s_sync != s_prev) begin
            cnt   <= '0;
            stale <= 1'b0;
            if (!stale) begin
               edge_stb <= 1'b1;
               iv       <= cnt + CNT_W'(1);
            end
         end else if (cnt != CNT_W'(TIMEOUT)) begin
            cnt <= cnt + CNT_W'(1);
         end else if (!stale) begin
            stale   <= 1'b1;
            tmo_stb <= 1'b1;
         end
      end
   end

   // R9: a silence report never coincides with a measured interval
   assert_tmo_excl_R9: assert property (@(posedge clk) disable iff (rst)
      tmo_stb |-> !edge_stb);
   // R9: silence is reported once, not every cycle
   assert_tmo_once_R9: assert property (@(posedge clk) disable iff (rst)
      tmo_stb |=> !tmo_stb);
endmodule

// File: rtl/ltc_rx_bit_slicer.sv
module ltc_rx_bit_slicer #(
   parameter int unsigned CNT_W      = 17,
   parameter int unsigned NOM_PERIOD = 800,
   parameter int unsigned MIN_PERIOD = 10,
   parameter int unsigned MAX_PERIOD = 24000,
   parameter int unsigned AVG_SHIFT  = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             edge_stb,
   input  logic [CNT_W-1:0] iv,
   input  logic             tmo_stb,
   output logic             bit_stb,
   output logic             bit_val,
   output logic             bit_err
);
   localparam int unsigned WW = CNT_W + AVG_SHIFT + 3;

   logic [CNT_W-1:0] est_q;
   logic             half_pend;
   logic [WW-1:0]    iv_x4, est_x3, avg_sum, avg, avg_clamped;
   logic             is_half;

   always_comb begin
      iv_x4   = WW'(iv) << 2;
      est_x3  = WW'(est_q) * WW'(3);
      is_half = iv_x4 < est_x3;
      avg_sum = WW'(est_q) * WW'((1 << AVG_SHIFT) - 1) + WW'(iv);
      avg     = avg_sum >> AVG_SHIFT;
      if (avg < WW'(MIN_PERIOD))      avg_clamped = WW'(MIN_PERIOD);
      else if (avg > WW'(MAX_PERIOD)) avg_clamped = WW'(MAX_PERIOD);
      else                            avg_clamped = avg;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         est_q     <= CNT_W'(NOM_PERIOD);
         half_pend <= 1'b0;
         bit_stb   <= 1'b0;
         bit_val   <= 1'b0;
         bit_err   <= 1'b0;
      end else begin
         bit_stb <= 1'b0;
         bit_err <= 1'b0;
         if (tmo_stb) begin
            half_pend <= 1'b0;
            bit_err   <= 1'b1;
         end else if (edge_stb) begin
            if (is_half) begin
               if (half_pend) begin
                  bit_stb   <= 1'b1;
                  bit_val   <= 1'b1;
                  half_pend <= 1'b0;
               end else begin
                  half_pend <= 1'b1;
               end
            end else if (half_pend) begin
               bit_err   <= 1'b1;
               half_pend <= 1'b0;
            end else begin
               bit_stb <= 1'b1;
               bit_val <= 1'b0;
               est_q   <= CNT_W'(avg_clamped);
            end
         end
      end
   end

   // R10: a decoded one always closes a pending half cell
   assert_one_pairs_R10: assert property (@(posedge clk) disable iff (rst)
      (bit_stb && bit_val) |-> ($past(half_pend) && !half_pend));
   // R10: a bit and an error are never reported together
   assert_bit_or_err_R10: assert property (@(posedge clk) disable iff (rst)
      $onehot0({bit_stb, bit_err}));
   // R11: the period estimate only moves on a decoded zero
   assert_est_on_zero_R11: assert property (@(posedge clk) disable iff (rst)
      !$stable(est_q) |-> (bit_stb && !bit_val));
endmodule

// File: rtl/ltc_rx_framer.sv
module ltc_rx_framer import ltc_rx_pkg::*; (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 bit_stb,
   input  logic                 bit_val,
   input  logic                 bit_err,
   output logic                 locked,
   output logic                 dir_bwd,
   output logic                 frame_stb,
   output logic [DATA_BITS-1:0] frame_q
);
   frm_state_t           state;
   logic [5:0]           cnt;
   logic [SYNC_BITS-1:0] hist, hist_next, sync_exp;
   logic [DATA_BITS-1:0] acc, acc_next;
   logic [5:0]           pos;
   logic                 wr_data;

   always_comb begin
      hist_next = {hist[SYNC_BITS-2:0], bit_val};
      sync_exp  = dir_bwd ? SYNC_BWD : SYNC_FWD;
      pos       = dir_bwd ? (6'd63 - cnt) : cnt;
      wr_data   = bit_stb && (state == FR_DATA);
   end

   for (genvar i = 0; i < DATA_BITS; i++) begin : g_acc
      assign acc_next[i] = (wr_data && (pos == 6'(i))) ? bit_val : acc[i];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= FR_HUNT;
         cnt       <= '0;
         hist      <= '0;
         acc       <= '0;
         frame_q   <= '0;
         frame_stb <= 1'b0;
         locked    <= 1'b0;
         dir_bwd   <= 1'b0;
      end else begin
         frame_stb <= 1'b0;
         if (bit_err) begin
            locked <= 1'b0;
            state  <= FR_HUNT;
            hist   <= '0;
         end else if (bit_stb) begin
            hist <= hist_next;
            acc  <= acc_next;
            unique case (state)
               FR_HUNT: begin
                  if (hist_next == SYNC_FWD) begin
                     locked  <= 1'b1;
                     dir_bwd <= 1'b0;
                     state   <= FR_DATA;
                     cnt     <= '0;
                  end else if (hist_next == SYNC_BWD) begin
                     locked  <= 1'b1;
                     dir_bwd <= 1'b1;
                     state   <= FR_DATA;
                     cnt     <= '0;
                  end
               end
               FR_DATA: begin
                  if (cnt == 6'd63) begin
                     frame_q   <= acc_next;
                     frame_stb <= 1'b1;
                     state     <= FR_SYNC;
                     cnt       <= '0;
                  end else begin
                     cnt <= cnt + 6'd1;
                  end
               end
               FR_SYNC: begin
                  if (cnt == 6'(SYNC_BITS - 1)) begin
                     cnt <= '0;
                     if (hist_next == sync_exp) begin
                        state <= FR_DATA;
                     end else begin
                        locked <= 1'b0;
                        state  <= FR_HUNT;
                     end
                  end else begin
                     cnt <= cnt + 6'd1;
                  end
               end
               default: state <= FR_HUNT;
            endcase
         end
      end
   end

   // R6: the frame report lasts one cycle
   assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (rst)
      frame_stb |=> !frame_stb);
   // R6: a frame is only reported while synchronized
   assert_irq_locked_R6: assert property (@(posedge clk) disable iff (rst)
      frame_stb |-> locked);
   // R7: buffer contents move only with a frame report
   assert_buf_hold_R7: assert property (@(posedge clk) disable iff (rst)
      !$stable(frame_q) |-> frame_stb);
   // R2, R3: lock rises only on a received sync word
   assert_lock_on_sync_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(locked) |-> ($past(bit_stb) &&
         (($past(hist_next) == SYNC_FWD) || ($past(hist_next) == SYNC_BWD))));
   // R3: direction holds while lock holds
   assert_dir_steady_R3: assert property (@(posedge clk) disable iff (rst)
      (locked && $past(locked)) |-> $stable(dir_bwd));
   // R8, R9: lock falls only on a decoded bit or a decode error
   assert_unlock_cause_R8: assert property (@(posedge clk) disable iff (rst)
      $fell(locked) |-> ($past(bit_stb) || $past(bit_err)));
endmodule

// File: rtl/ltc_rx.sv
module ltc_rx import ltc_rx_pkg::*; #(
   parameter int unsigned NOM_PERIOD = 800,
   parameter int unsigned FAST_MUL   = 80,
   parameter int unsigned SLOW_DIV   = 30,
   parameter int unsigned AVG_SHIFT  = 2
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       ltc_line,
   input  logic [2:0] rd_addr,
   output logic [7:0] rd_data,
   output logic       lock,
   output logic       dir_bwd,
   output logic       rx_irq
);
   localparam int unsigned MIN_P   = NOM_PERIOD / FAST_MUL;
   localparam int unsigned MAX_P   = NOM_PERIOD * SLOW_DIV;
   localparam int unsigned TIMEOUT = 2 * MAX_P;
   localparam int unsigned CNT_W   = $clog2(TIMEOUT + 2);

   if (MIN_P < 4) begin : g_bad_min
      $error("ltc_rx: NOM_PERIOD/FAST_MUL must be at least 4 clocks");
   end
   if (AVG_SHIFT < 1 || AVG_SHIFT > 6) begin : g_bad_shift
      $error("ltc_rx: AVG_SHIFT must lie in 1..6");
   end

   logic             edge_stb, tmo_stb;
   logic [CNT_W-1:0] iv;
   logic             bit_stb, bit_val, bit_err;
   logic [DATA_BITS-1:0] frame;
   logic [7:0]       bytes [BYTE_CNT];

   ltc_rx_edge_timer #(.TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) i_timer (
      .clk(clk), .rst(rst), .line_in(ltc_line),
      .edge_stb(edge_stb), .iv(iv), .tmo_stb(tmo_stb)
   );

   ltc_rx_bit_slicer #(
      .CNT_W(CNT_W), .NOM_PERIOD(NOM_PERIOD), .MIN_PERIOD(MIN_P),
      .MAX_PERIOD(MAX_P), .AVG_SHIFT(AVG_SHIFT)
   ) i_slicer (
      .clk(clk), .rst(rst), .edge_stb(edge_stb), .iv(iv), .tmo_stb(tmo_stb),
      .bit_stb(bit_stb), .bit_val(bit_val), .bit_err(bit_err)
   );

   ltc_rx_framer i_framer (
      .clk(clk), .rst(rst), .bit_stb(bit_stb), .bit_val(bit_val),
      .bit_err(bit_err), .locked(lock), .dir_bwd(dir_bwd),
      .frame_stb(rx_irq), .frame_q(frame)
   );

   for (genvar b = 0; b < BYTE_CNT; b++) begin : g_byte
      assign bytes[b] = frame[8*b +: 8];
   end

   assign rd_data = bytes[rd_addr];
endmodule

// File: tb/test_ltc_rx.sv
module test_ltc_rx;
   localparam int CLK_PERIOD = 10;
   localparam int P_NOM      = 64;
   localparam int IDLE_WAIT  = 4200;
   localparam logic [15:0] S_FWD = 16'h3FFD;
   localparam logic [15:0] S_BWD = 16'hBFFC;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       ltc_drv = 1'b0;
   logic [2:0] rd_addr = 3'd0;
   logic [7:0] rd_data;
   logic       lock, dir_bwd, rx_irq;

   int checks = 0;
   int failures = 0;
   int irq_cnt = 0;
   int irq_wide = 0;
   logic irq_prev = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ltc_rx #(.NOM_PERIOD(P_NOM), .FAST_MUL(8), .SLOW_DIV(30), .AVG_SHIFT(2)) i_ltc_rx (
      .clk(clk), .rst(rst), .ltc_line(ltc_drv), .rd_addr(rd_addr),
      .rd_data(rd_data), .lock(lock), .dir_bwd(dir_bwd), .rx_irq(rx_irq)
   );

   always @(negedge clk) begin
      if (rx_irq) irq_cnt++;
      if (rx_irq && irq_prev) irq_wide++;
      irq_prev = rx_irq;
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input logic b, input int p);
      ltc_drv = ~ltc_drv;
      if (b) begin
         wait_clk(p / 2);
         ltc_drv = ~ltc_drv;
         wait_clk(p - p / 2);
      end else begin
         wait_clk(p);
      end
   endtask

   task automatic send_fwd(input logic [63:0] d, input logic [15:0] s, input int p);
      for (int i = 0; i < 64; i++) send_bit(d[i], p);
      for (int i = 15; i >= 0; i--) send_bit(s[i], p);
   endtask

   task automatic send_bwd(input logic [63:0] d, input int p);
      for (int i = 15; i >= 0; i--) send_bit(S_BWD[i], p);
      for (int i = 63; i >= 0; i--) send_bit(d[i], p);
   endtask

   task automatic close_edge();
      ltc_drv = ~ltc_drv;
      wait_clk(20);
   endtask

   task automatic read_buf(output logic [63:0] v);
      v = '0;
      for (int a = 0; a < 8; a++) begin
         rd_addr = 3'(a);
         #1;
         v[8*a +: 8] = rd_data;
      end
   endtask

   logic [63:0] rb;
   int          irq0;

   task automatic t_reset();
      chk("R1 lock", 64'(lock), 64'd0);
      chk("R1 dir", 64'(dir_bwd), 64'd0);
      chk("R1 irq", 64'(irq_cnt), 64'd0);
      read_buf(rb);
      chk("R1 buffer", rb, 64'd0);
   endtask

   task automatic t_forward();
      irq0 = irq_cnt;
      send_fwd(64'h0000_0000_FFFF_0000, S_FWD, P_NOM);
      send_fwd(64'hA5C3_1E0F_7D82_B469, S_FWD, P_NOM);
      close_edge();
      chk("R2 lock", 64'(lock), 64'd1);
      chk("R2 dir", 64'(dir_bwd), 64'd0);
      chk("R6 one irq", 64'(irq_cnt - irq0), 64'd1);
      read_buf(rb);
      chk("R4 forward order", rb, 64'hA5C3_1E0F_7D82_B469);
      wait_clk(IDLE_WAIT);
      chk("R9 silence unlocks", 64'(lock), 64'd0);
   endtask

   task automatic t_backward();
      irq0 = irq_cnt;
      send_bwd(64'h1234_5678_9ABC_DEF0, P_NOM);
      close_edge();
      chk("R3 lock", 64'(lock), 64'd1);
      chk("R3 dir", 64'(dir_bwd), 64'd1);
      chk("R6 bwd irq", 64'(irq_cnt - irq0), 64'd1);
      read_buf(rb);
      chk("R5 backward order", rb, 64'h1234_5678_9ABC_DEF0);
      wait_clk(IDLE_WAIT);
   endtask

   task automatic t_no_sync();
      irq0 = irq_cnt;
      for (int i = 0; i < 64; i++) send_bit(i[0], P_NOM);
      close_edge();
      chk("R6 no sync no irq", 64'(irq_cnt - irq0), 64'd0);
      chk("R2 no sync no lock", 64'(lock), 64'd0);
      read_buf(rb);
      chk("R7 buffer kept", rb, 64'h1234_5678_9ABC_DEF0);
      wait_clk(IDLE_WAIT);
   endtask

   task automatic t_missed_sync();
      irq0 = irq_cnt;
      send_fwd(64'h0000_0000_FFFF_0000, S_FWD, P_NOM);
      send_fwd(64'h0F1E_2D3C_4B5A_6978, 16'h3FDD, P_NOM);
      close_edge();
      chk("R6 irq before sync check", 64'(irq_cnt - irq0), 64'd1);
      chk("R8 missed sync unlocks", 64'(lock), 64'd0);
      read_buf(rb);
      chk("R4 data of missed frame", rb, 64'h0F1E_2D3C_4B5A_6978);
      wait_clk(IDLE_WAIT);
   endtask

   task automatic t_invalid();
      irq0 = irq_cnt;
      send_fwd(64'h0000_0000_FFFF_0000, S_FWD, P_NOM);
      send_bit(1'b0, P_NOM);
      send_bit(1'b0, P_NOM);
      wait_clk(20);
      chk("R2 lock before bad cell", 64'(lock), 64'd1);
      ltc_drv = ~ltc_drv;
      wait_clk(P_NOM / 2);
      ltc_drv = ~ltc_drv;
      wait_clk(P_NOM);
      close_edge();
      chk("R9 invalid bit unlocks", 64'(lock), 64'd0);
      chk("R6 aborted no irq", 64'(irq_cnt - irq0), 64'd0);
      read_buf(rb);
      chk("R7 aborted keeps buffer", rb, 64'h0F1E_2D3C_4B5A_6978);
      wait_clk(IDLE_WAIT);
   endtask

   task automatic t_speed();
      irq0 = irq_cnt;
      send_fwd(64'h0000_0000_FFFF_0000, S_FWD, 56);
      send_fwd(64'hC0DE_0000_BEEF_0101, S_FWD, 44);
      close_edge();
      chk("R11 tracked irq", 64'(irq_cnt - irq0), 64'd1);
      chk("R11 tracked lock", 64'(lock), 64'd1);
      read_buf(rb);
      chk("R10 R11 data at faster rate", rb, 64'hC0DE_0000_BEEF_0101);
      wait_clk(IDLE_WAIT);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      wait_clk(5);
      rst = 1'b0;
      wait_clk(3);
      t_reset();
      t_forward();
      t_backward();
      t_no_sync();
      t_missed_sync();
      t_invalid();
      t_speed();
      chk("R6 irq single cycle", 64'(irq_wide), 64'd0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule